// File: doc/BRIEF.md
# Per-Frame Short Command Injector

This block keeps a small table of display-command short-write packets and replays it on the link at the start of every video frame, with no software involvement after setup. Software supplies each command as a pair of bytes: a command index and one parameter value. The block turns each pair into a complete 32-bit short packet header in hardware. It fixes the data type, places the index and the value, and computes the 8-bit header error-correcting code.

Commands can be written straight into a numbered slot, or appended one after another through a load port that fills slots 0, 1, 2 and so on. A control word sets how many bytes go out per frame and whether the replay is enabled. On each frame-start strobe the stored words leave, least-significant byte first, on a byte stream with valid/ready handshaking. Software writes made while a frame is being sent affect only the following frame. A frame-start strobe that arrives during a transmission is dropped.

Top module: `dcs_frame_injector`

## Requirements
- R1: Each stored packet word holds data type 0x15 in bits 7:0, the command index (write data bits 7:0) in bits 15:8, the parameter value (write data bits 15:8) in bits 23:16 and the ECC in bits 31:24.
- R2: The ECC is the XOR, over every set bit b among the 24 low header bits, of a 6-bit constant for b. For bits 0..23 the constants are 07,0B,0D,0E,13,15,16,19,1A,1C,23,25,26,29,2A,2C,31,32,34,38,1F,2F,37,3B (hex).
- R3: A write to address 0x1B+k (k = 0..7) stores a packet in slot k. Each write to the append address 0x19 stores a packet in the next free slot, starting at slot 0 after any control write.
- R4: An append made when all eight slots have already been filled by appends is not stored, and it sets load_err. A control write clears load_err.
- R5: The control word at address 0x1A holds the byte count in bits 5:0 and the enable in bit 15. On a frame-start strobe with the enable set and a nonzero count, the block sends min(count, 32) bytes. Byte i is bits 8*(i%4)+7 : 8*(i%4) of slot i/4. With the enable clear, or with a zero count, nothing is sent.
- R6: The same sequence is sent again on every later frame-start strobe, with no further writes needed.
- R7: A frame-start strobe that arrives while busy is ignored: the frame in progress still sends exactly its byte count, and no extra frame follows.
- R8: Slot or control writes made while busy do not change the frame in progress. They take effect from the next frame.
- R9: After reset all slots are zero, the enable is clear, and busy, tx_valid and load_err are low.
- R10: While tx_valid is high and tx_ready is low, tx_data and tx_valid hold. busy equals tx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register word address |
| wr_data | input | 16 | Write data (command bytes or control word) |
| frame_start | input | 1 | One-cycle frame-start strobe |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Link accepts the byte |
| tx_data | output | 8 | Output byte |
| busy | output | 1 | A frame's command sequence is in transmission |
| load_err | output | 1 | Append attempted with all slots full |

## Verification
A wrong header or ECC bit in a slot shows up in the first frame that covers that slot, as one wrong byte at a predictable position. The bench sweeps every index value so that each ECC input bit is exercised. A corrupted byte pointer or length register shows within one frame as a wrong byte, a wrong byte count, or busy that never drops. A broken append pointer or shadow copy shows as the wrong slot contents in the next frame, and a lost or spurious load_err shows on the cycle after the ninth append.

// File: rtl/dcs_inj_pkg.sv
// Shared constants and the header ECC function for the frame command injector.
// Assumes the 24 protected header bits are the low 24 bits of the word.
package dcs_inj_pkg;

    localparam logic [7:0] SHORT_W1_TYPE = 8'h15;
    localparam int         HDR_BITS      = 24;

    // Parity constant contributed by one protected header bit.
    function automatic logic [5:0] ecc_term(input int unsigned b);
        logic [5:0] t;
        case (b)
            0: t = 6'h07;  1: t = 6'h0B;  2: t = 6'h0D;  3: t = 6'h0E;
            4: t = 6'h13;  5: t = 6'h15;  6: t = 6'h16;  7: t = 6'h19;
            8: t = 6'h1A;  9: t = 6'h1C; 10: t = 6'h23; 11: t = 6'h25;
           12: t = 6'h26; 13: t = 6'h29; 14: t = 6'h2A; 15: t = 6'h2C;
           16: t = 6'h31; 17: t = 6'h32; 18: t = 6'h34; 19: t = 6'h38;
           20: t = 6'h1F; 21: t = 6'h2F; 22: t = 6'h37; 23: t = 6'h3B;
            default: t = 6'h00;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/dcs_hdr_gen.sv
// Builds one short-write packet header from an index and a value byte.
// Purely combinational; the ECC is one XOR tree over masked parity terms.
module dcs_hdr_gen
    import dcs_inj_pkg::*;
(
    input  logic [7:0]  cmd_idx,
    input  logic [7:0]  cmd_val,
    output logic [31:0] hdr
);
    logic [HDR_BITS-1:0] body;
    logic [5:0]          term [HDR_BITS];
    logic [5:0]          ecc6;

    assign body = {cmd_val, cmd_idx, SHORT_W1_TYPE};

    // One masked parity term per protected header bit.
    for (genvar b = 0; b < HDR_BITS; b++) begin : g_term
        assign term[b] = body[b] ? ecc_term(b) : 6'h00;
    end

    // XOR reduction of all parity terms.
    always_comb begin
        ecc6 = 6'h00;
        for (int b = 0; b < HDR_BITS; b++) ecc6 = ecc6 ^ term[b];
    end

    assign hdr = {2'b00, ecc6, body};

endmodule

// File: rtl/dcs_inj_regs.sv
// Software-visible register file: packet slots, append loader, control word.
// Assumes a single-cycle write strobe; slot writes store an ECC-complete header.
module dcs_inj_regs #(
    parameter int N_SLOTS     = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 6,
    parameter int EN_BIT      = 15,
    parameter int SLOT_BASE   = 'h1B,
    parameter int CTRL_ADDR   = 'h1A,
    parameter int APPEND_ADDR = 'h19
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [N_SLOTS-1:0][31:0]  slots,
    output logic                      seq_en,
    output logic [CNT_W-1:0]          byte_cnt,
    output logic                      load_err
);
    localparam int PTR_W = $clog2(N_SLOTS + 1);

    logic [31:0]      new_hdr;
    logic [PTR_W-1:0] app_ptr_q;
    logic             app_full;
    logic             ctrl_wr;
    logic             app_wr;
    logic             unused_ctrl_bits;

    assign unused_ctrl_bits = ^wr_data[EN_BIT-1:CNT_W];

    dcs_hdr_gen u_hdr (
        .cmd_idx (wr_data[7:0]),
        .cmd_val (wr_data[15:8]),
        .hdr     (new_hdr)
    );

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign app_wr   = wr_en && (wr_addr == ADDR_W'(APPEND_ADDR));
    assign app_full = (app_ptr_q == PTR_W'(N_SLOTS));

    // One storage register per slot, loaded by direct or append write.
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = (wr_en && (wr_addr == ADDR_W'(SLOT_BASE + k))) ||
                     (app_wr && !app_full && (app_ptr_q == PTR_W'(k)));
        // Slot k storage.
        always_ff @(posedge clk) begin
            if (!rst_n)   slots[k] <= '0;
            else if (hit) slots[k] <= new_hdr;
        end
    end

    // Control word, append pointer and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_en    <= 1'b0;
            byte_cnt  <= '0;
            app_ptr_q <= '0;
            load_err  <= 1'b0;
        end else if (ctrl_wr) begin
            seq_en    <= wr_data[EN_BIT];
            byte_cnt  <= wr_data[CNT_W-1:0];
            app_ptr_q <= '0;
            load_err  <= 1'b0;
        end else if (app_wr) begin
            if (app_full) load_err  <= 1'b1;
            else          app_ptr_q <= app_ptr_q + 1'b1;
        end
    end

    // R3
    app_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_ptr_q <= PTR_W'(N_SLOTS));

    // R4
    load_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> $past(app_wr && app_full));

    // R4
    full_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (app_wr && app_full && !(wr_en && wr_addr >= ADDR_W'(SLOT_BASE)
                                 && wr_addr < ADDR_W'(SLOT_BASE + N_SLOTS)))
        |=> $stable(slots));

endmodule

// File: rtl/dcs_inj_seq.sv
// Per-frame sequencer: snapshots the slots and control at frame start, then
// streams the snapshot out byte by byte on a valid/ready interface.
// Assumes frame_start is a single-cycle pulse; pulses while busy are dropped.
module dcs_inj_seq #(
    parameter int N_SLOTS = 8,
    parameter int CNT_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOTS-1:0][31:0]  slots,
    input  logic                      seq_en,
    input  logic [CNT_W-1:0]          byte_cnt,
    input  logic                      frame_start,
    input  logic                      tx_ready,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    output logic                      busy
);
    localparam int MAX_BYTES = 4 * N_SLOTS;
    localparam int BP_W      = $clog2(MAX_BYTES);

    logic [N_SLOTS-1:0][31:0] act_q;
    logic [BP_W-1:0]          ptr_q;
    logic [BP_W-1:0]          last_q;
    logic [BP_W-1:0]          last_d;
    logic                     busy_q;
    logic                     start;
    logic                     fin;

    // Capped frame length, expressed as the index of the final byte.
    always_comb begin
        if (int'(byte_cnt) > MAX_BYTES) last_d = BP_W'(MAX_BYTES - 1);
        else                            last_d = BP_W'(int'(byte_cnt) - 1);
    end

    assign start = frame_start && !busy_q && seq_en && (byte_cnt != '0);
    assign fin   = busy_q && tx_ready && (ptr_q == last_q);

    // Snapshot, byte pointer and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            ptr_q  <= '0;
            last_q <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            act_q  <= slots;
            ptr_q  <= '0;
            last_q <= last_d;
            busy_q <= 1'b1;
        end else if (fin) begin
            busy_q <= 1'b0;
        end else if (busy_q && tx_ready) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    assign tx_valid = busy_q;
    assign busy     = busy_q;
    assign tx_data  = act_q[ptr_q[BP_W-1:2]][{ptr_q[1:0], 3'b000} +: 8];

    // R10
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && tx_ready && ptr_q != last_q) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R5
    end_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(tx_ready));

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && frame_start && !tx_ready) |=> (busy_q && $stable(ptr_q) && $stable(act_q)));

    // R8
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fin) |=> $stable(act_q));

endmodule

// File: rtl/dcs_frame_injector.sv
// Top level: per-frame short-command injector. Register file feeds a sequencer
// that replays the stored packet headers on every enabled frame start.
// Assumes one register write per cycle and a byte-wide link with ready.
module dcs_frame_injector #(
    parameter int N_SLOTS     = 8,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 6,
    parameter int EN_BIT      = 15,
    parameter int SLOT_BASE   = 'h1B,
    parameter int CTRL_ADDR   = 'h1A,
    parameter int APPEND_ADDR = 'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              busy,
    output logic              load_err
);
    logic [N_SLOTS-1:0][31:0] slots;
    logic                     seq_en;
    logic [CNT_W-1:0]         byte_cnt;

    dcs_inj_regs #(
        .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .EN_BIT(EN_BIT), .SLOT_BASE(SLOT_BASE), .CTRL_ADDR(CTRL_ADDR),
        .APPEND_ADDR(APPEND_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slots(slots), .seq_en(seq_en),
        .byte_cnt(byte_cnt), .load_err(load_err)
    );

    dcs_inj_seq #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .slots(slots), .seq_en(seq_en),
        .byte_cnt(byte_cnt), .frame_start(frame_start), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
    );

    // R10
    busy_tracks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tx_valid);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tx_valid && !load_err));

endmodule

// File: tb/dcs_frame_injector_bench.sv
// Self-checking bench: sweeps command bytes, slot/append loading, lengths,
// backpressure and mid-frame events; expected bytes computed from the spec.
module dcs_frame_injector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        busy;
    logic        load_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_slot [8];
    int          m_cnt = 0;
    bit          m_en = 1'b0;
    logic [7:0]  cap [64];
    int          ncap;
    int          stall_bad;

    always #2.5 clk = ~clk;

    dcs_frame_injector u_dcs_frame_injector (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .busy(busy), .load_err(load_err)
    );

    // Expected header from index and value per R1/R2.
    function automatic logic [31:0] exp_hdr(input logic [7:0] idx, input logic [7:0] val);
        logic [5:0] k [24] = '{6'h07,6'h0B,6'h0D,6'h0E,6'h13,6'h15,6'h16,6'h19,
                               6'h1A,6'h1C,6'h23,6'h25,6'h26,6'h29,6'h2A,6'h2C,
                               6'h31,6'h32,6'h34,6'h38,6'h1F,6'h2F,6'h37,6'h3B};
        logic [23:0] h = {val, idx, 8'h15};
        logic [5:0]  e = '0;
        for (int i = 0; i < 24; i++) if (h[i]) e ^= k[i];
        return {2'b00, e, h};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_slot(input int k, input logic [7:0] idx, input logic [7:0] val);
        wr(8'(8'h1B + k), {val, idx});
        m_slot[k] = exp_hdr(idx, val);
    endtask

    task automatic set_ctrl(input bit en, input int cnt);
        wr(8'h1A, {en, 9'd0, 6'(cnt)});
        m_en = en; m_cnt = cnt;
    endtask

    // Pulse frame_start and capture accepted bytes over a fixed window.
    // rmode 1 stalls every third cycle; fs_at/wr_at inject mid-frame events.
    task automatic run_frame(input int win, input int rmode, input int fs_at,
                             input int wr_at, input logic [7:0] wa, input logic [15:0] wd);
        logic       pv = 1'b0;
        logic [7:0] pd = '0;
        ncap = 0; stall_bad = 0;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        for (int c = 0; c < win; c++) begin
            frame_start = (c == fs_at);
            wr_en   = (c == wr_at);
            wr_addr = wa; wr_data = wd;
            tx_ready = (rmode == 0) ? 1'b1 : ((c % 3) != 2);
            if (pv && (!tx_valid || tx_data != pd)) stall_bad++;
            if (tx_valid && tx_ready && ncap < 64) begin
                cap[ncap] = tx_data; ncap++;
            end
            pv = tx_valid && !tx_ready; pd = tx_data;
            @(negedge clk);
        end
        frame_start = 1'b0; wr_en = 1'b0; tx_ready = 1'b1;
    endtask

    function automatic int exp_len();
        if (!m_en) return 0;
        return (m_cnt > 32) ? 32 : m_cnt;
    endfunction

    // Compare captured frame with model; returns first mismatch index or -1.
    function automatic int frame_diff();
        for (int i = 0; i < ncap; i++)
            if (cap[i] != m_slot[i / 4][8 * (i % 4) +: 8]) return i;
        return -1;
    endfunction

    task automatic check_frame(input string req);
        int d;
        check(ncap == exp_len(), req, ncap, exp_len());
        d = frame_diff();
        check(d < 0, req, (d < 0) ? 0 : int'(cap[d]),
              (d < 0) ? 0 : int'(m_slot[d / 4][8 * (d % 4) +: 8]));
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_slot[k] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        check(!busy && !tx_valid && !load_err, "R9 reset outputs", {busy, tx_valid, load_err}, 0);
        rst_n = 1'b1;
        // R9: enable clear after reset, so nothing goes out
        run_frame(20, 0, -1, -1, 8'h0, 16'h0);
        check(ncap == 0, "R9 enable clear", ncap, 0);
        // R9: slots zero after reset
        set_ctrl(1'b1, 32);
        run_frame(45, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R9 slots zero");

        // R1 R2: sweep every index with varying values through slot 0
        set_ctrl(1'b1, 4);
        for (int i = 0; i < 256; i++) begin
            set_slot(0, 8'(i), 8'(i * 37 + 11));
            run_frame(8, 0, -1, -1, 8'h0, 16'h0);
            check_frame("R1 R2 header/ecc sweep");
        end
        // R2: each single value bit
        for (int b = 0; b < 8; b++) begin
            set_slot(0, 8'h00, 8'(1 << b));
            run_frame(8, 0, -1, -1, 8'h0, 16'h0);
            check_frame("R2 value bit");
        end

        // R3 R5: direct slot addressing, full 32-byte frame
        for (int k = 0; k < 8; k++) set_slot(k, 8'(8'h30 + k), 8'(8'hC0 ^ k));
        set_ctrl(1'b1, 32);
        run_frame(45, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R3 R5 direct slots");
        // R6: repeats without new writes
        run_frame(45, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R6 second frame");
        run_frame(45, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R6 third frame");

        // R5: lengths, partial word, zero, cap above 32
        for (int n = 0; n < 64; n++) begin
            set_ctrl(1'b1, n);
            run_frame(40, 0, -1, -1, 8'h0, 16'h0);
            check_frame("R5 length sweep");
        end
        set_ctrl(1'b0, 12);
        run_frame(20, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R5 disabled");

        // R10: backpressure holds data
        set_ctrl(1'b1, 32);
        run_frame(70, 1, -1, -1, 8'h0, 16'h0);
        check_frame("R10 stalled frame");
        check(stall_bad == 0, "R10 hold under stall", stall_bad, 0);

        // R7: frame start mid-frame is ignored
        set_ctrl(1'b1, 20);
        run_frame(80, 1, 10, -1, 8'h0, 16'h0);
        check_frame("R7 mid-frame start");

        // R8: slot write during busy affects next frame only
        run_frame(40, 0, -1, 5, 8'h1B, 16'h5AA5);
        check_frame("R8 frame in progress");
        m_slot[0] = exp_hdr(8'hA5, 8'h5A);
        run_frame(40, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R8 next frame");
        // R8: control write during busy affects next frame only
        run_frame(40, 0, -1, 5, 8'h1A, 16'h8007);
        check_frame("R8 ctrl during busy");
        m_cnt = 7;
        run_frame(40, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R8 ctrl next frame");

        // R3 R4: append loading and overflow
        set_ctrl(1'b1, 32);
        for (int k = 0; k < 8; k++) begin
            wr(8'h19, {8'(8'h70 + k), 8'(8'h10 + k)});
            m_slot[k] = exp_hdr(8'(8'h10 + k), 8'(8'h70 + k));
        end
        check(load_err == 1'b0, "R4 no error at eight", load_err, 0);
        wr(8'h19, 16'hEEDD);
        check(load_err == 1'b1, "R4 error on ninth", load_err, 1);
        run_frame(45, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R3 R4 appended slots, excess dropped");
        set_ctrl(1'b1, 4);
        check(load_err == 1'b0, "R4 cleared by ctrl", load_err, 0);
        wr(8'h19, 16'h1234);
        m_slot[0] = exp_hdr(8'h34, 8'h12);
        run_frame(10, 0, -1, -1, 8'h0, 16'h0);
        check_frame("R3 append restarts at slot 0");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule